// File: doc/BRIEF.md
# Multi-Queue Transmit Channel Scheduler

This block keeps the control state of sixteen circular transmit rings and feeds their work into eight DMA channels. Each ring has an 8-bit producer index that software moves and an 8-bit consumer index that the scheduler moves. A per-ring status word marks the ring active, names the channel it feeds and selects its service mode. Several rings may share one channel. A channel-enable mask gates each channel as a whole.

Every enabled channel picks one eligible ring, round-robin among the rings mapped to it. It then presents a request that carries the ring number and that ring's current consumer index. When the downstream engine grants the request, the consumer index steps by one and, if that ring's interrupt bit is set, a one-cycle interrupt pulse follows. Software reaches all state through a flat word-addressed register port, with a synchronous write and a combinational read.

Top module: `txq_sched`

## Requirements
- R1: After reset every index, status word, mask and flag reads zero, no request is raised and no interrupt is pending.
- R2: Addresses are {bank[5:4], index[3:0]}. Bank 0 holds the control registers: index 0 is the channel enable, 1 the empty flags, 2 the chain select and 3 the interrupt mask. Bank 1 holds the producer indexes, bank 2 the consumer indexes and bank 3 the status words, each indexed by ring number. Unmapped addresses read zero.
- R3: A status write updates bit k (k = 0..9) only when bit k+10 of the written data is 1. Every other stored bit keeps its value.
- R4: An empty-flag write changes flag q only when data bit q+16 is 1, setting it to data bit q. A ring whose flag is 1 is never selected.
- R5: A ring is eligible when all of the following hold: status bit 0 is 1; its consumer and producer indexes differ; its channel field (status bits 4:1) is below 8; and that channel's bit in the enable register is 1.
- R6: When status bit 8 is 1 (scheduler-ack mode), the ring is eligible only while status bit 5 (window space left) is also 1. When bit 8 is 0 (in-order mode), bit 5 is ignored.
- R7: An idle channel with an eligible ring raises its request in the next cycle. The request carries the ring number and the ring's live consumer index, and it keeps the same ring until a grant or a drop.
- R8: A grant on a raised request advances that ring's consumer index by one, modulo 256. The request falls in the next cycle, and a new selection can appear one cycle after that.
- R9: Among eligible rings on a channel, selection starts at the ring after the last one granted on that channel, with ring 0 first after reset.
- R10: A held request drops in the cycle after its ring stops being eligible for that channel.
- R11: A granted ring whose interrupt-mask bit is 1 pulses its interrupt output high for exactly the cycle after the grant.
- R12: If software writes a consumer index in the same cycle as a grant on that ring, the written value is kept. The interrupt pulse still follows.
- R13: Chain select stores bits 15:0 and reads them back. It has no effect on selection or on the requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register address {bank, index} |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i |
| req_o | output | 8 | Per-channel request |
| req_q_o | output | 32 | Per-channel ring number, 4 bits per channel |
| req_ptr_o | output | 64 | Per-channel consumer index, 8 bits per channel |
| gnt_i | input | 8 | Per-channel grant |
| irq_o | output | 16 | Per-ring interrupt pulse |

## Verification
A software write to a ring's consumer index can land in the same cycle as a grant that advances that index. A status write that takes a ring out of service can also land in the same cycle that its request is being held or granted. The bench forces a grant on a held request while writing the consumer index of the same ring. It then reads the index back and expects the written value, and it also expects the interrupt pulse. A long stretch of random register writes mixed with random grants raises the other collisions, and a behavioural model compares the requests, interrupts and read data against the design on every clock.

// File: rtl/txq_sched_pkg.sv
package txq_sched_pkg;
  localparam int DATA_W    = 32;
  localparam int ST_W      = 10;
  localparam int ST_ACT    = 0;
  localparam int ST_CH_LSB = 1;
  localparam int ST_CH_W   = 4;
  localparam int ST_WSL    = 5;
  localparam int ST_ACK    = 8;
  localparam int ST_EN_LSB = 10;
  localparam int MASK_LSB  = 16;

  typedef enum logic [1:0] {
    BANK_CTL = 2'd0,
    BANK_WR  = 2'd1,
    BANK_RD  = 2'd2,
    BANK_ST  = 2'd3
  } bank_e;

  localparam int CTL_CHEN  = 0;
  localparam int CTL_EMPTY = 1;
  localparam int CTL_CHAIN = 2;
  localparam int CTL_IMASK = 3;
endpackage

// File: rtl/txq_regs.sv
module txq_regs
  import txq_sched_pkg::*;
#(
  parameter int NUM_Q  = 16,
  parameter int NUM_CH = 8,
  parameter int PTR_W  = 8,
  parameter int IDX_W  = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [IDX_W+1:0]         addr_i,
  input  logic [DATA_W-1:0]        wdata_i,
  output logic [DATA_W-1:0]        rdata_o,
  input  logic [NUM_Q-1:0]         adv_i,
  output logic [NUM_Q*PTR_W-1:0]   rd_ptr_o,
  output logic [NUM_Q-1:0]         elig_o,
  output logic [NUM_Q*ST_CH_W-1:0] qch_o,
  output logic [NUM_Q-1:0]         irq_o
);
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  bank_e            bank;
  logic [IDX_W-1:0] idx;
  assign bank = bank_e'(addr_i[IDX_W+1:IDX_W]);
  assign idx  = addr_i[IDX_W-1:0];

  logic [NUM_CH-1:0] chen_q;
  logic [NUM_Q-1:0]  empty_q, chain_q, imask_q, irq_q;
  logic [NUM_Q*PTR_W-1:0] wr_flat;
  logic [NUM_Q*ST_W-1:0]  st_flat;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chen_q  <= '0;
      empty_q <= '0;
      chain_q <= '0;
      imask_q <= '0;
      irq_q   <= '0;
    end else begin
      irq_q <= adv_i & imask_q;
      if (we_i && bank == BANK_CTL) begin
        case (int'(idx))
          CTL_CHEN:  chen_q  <= wdata_i[NUM_CH-1:0];
          CTL_EMPTY: empty_q <= (empty_q & ~wdata_i[MASK_LSB +: NUM_Q]) |
                                (wdata_i[NUM_Q-1:0] & wdata_i[MASK_LSB +: NUM_Q]);
          CTL_CHAIN: chain_q <= wdata_i[NUM_Q-1:0];
          CTL_IMASK: imask_q <= wdata_i[NUM_Q-1:0];
          default: ;
        endcase
      end
    end
  end
  assign irq_o = irq_q;

  for (genvar q = 0; q < NUM_Q; q++) begin : g_q
    logic [PTR_W-1:0]   wr_q, rd_q;
    logic [ST_W-1:0]    st_q;
    logic [ST_CH_W-1:0] ch;
    logic               sel, ch_ok, mode_ok;

    assign sel = we_i && (idx == IDX_W'(q));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        wr_q <= '0;
        rd_q <= '0;
        st_q <= '0;
      end else begin
        if (sel && bank == BANK_WR) wr_q <= wdata_i[PTR_W-1:0];
        if (sel && bank == BANK_RD) rd_q <= wdata_i[PTR_W-1:0];
        else if (adv_i[q])          rd_q <= rd_q + 1'b1;
        if (sel && bank == BANK_ST)
          st_q <= (st_q & ~wdata_i[ST_EN_LSB +: ST_W]) |
                  (wdata_i[ST_W-1:0] & wdata_i[ST_EN_LSB +: ST_W]);
      end
    end

    assign ch      = st_q[ST_CH_LSB +: ST_CH_W];
    assign ch_ok   = (int'(ch) < NUM_CH) && chen_q[ch[CH_W-1:0]];
    assign mode_ok = !st_q[ST_ACK] || st_q[ST_WSL];
    assign elig_o[q] = st_q[ST_ACT] && (rd_q != wr_q) && !empty_q[q] && mode_ok && ch_ok;

    assign rd_ptr_o[q*PTR_W +: PTR_W]   = rd_q;
    assign wr_flat[q*PTR_W +: PTR_W]    = wr_q;
    assign st_flat[q*ST_W +: ST_W]      = st_q;
    assign qch_o[q*ST_CH_W +: ST_CH_W]  = ch;
  end

  always_comb begin
    rdata_o = '0;
    case (bank)
      BANK_CTL: begin
        case (int'(idx))
          CTL_CHEN:  rdata_o[NUM_CH-1:0] = chen_q;
          CTL_EMPTY: rdata_o[NUM_Q-1:0]  = empty_q;
          CTL_CHAIN: rdata_o[NUM_Q-1:0]  = chain_q;
          CTL_IMASK: rdata_o[NUM_Q-1:0]  = imask_q;
          default: ;
        endcase
      end
      BANK_WR: if (int'(idx) < NUM_Q) rdata_o[PTR_W-1:0] = wr_flat[idx*PTR_W +: PTR_W];
      BANK_RD: if (int'(idx) < NUM_Q) rdata_o[PTR_W-1:0] = rd_ptr_o[idx*PTR_W +: PTR_W];
      BANK_ST: if (int'(idx) < NUM_Q) rdata_o[ST_W-1:0]  = st_flat[idx*ST_W +: ST_W];
      default: ;
    endcase
  end
endmodule

// File: rtl/txq_arb.sv
module txq_arb #(
  parameter int NUM_Q = 16,
  parameter int QW    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NUM_Q-1:0] cand_i,
  input  logic             gnt_i,
  output logic             req_o,
  output logic [QW-1:0]    req_q_o
);
  logic          req_v_q;
  logic [QW-1:0] req_sel_q, last_q, pick;
  logic          pick_v;

  always_comb begin
    pick_v = 1'b0;
    pick   = '0;
    for (int k = 1; k <= NUM_Q; k++) begin
      int n;
      n = int'(last_q) + k;
      if (n >= NUM_Q) n = n - NUM_Q;
      if (!pick_v && cand_i[n]) begin
        pick_v = 1'b1;
        pick   = QW'(n);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_v_q   <= 1'b0;
      req_sel_q <= '0;
      last_q    <= QW'(NUM_Q - 1);
    end else if (req_v_q && gnt_i) begin
      req_v_q <= 1'b0;
      last_q  <= req_sel_q;
    end else if (req_v_q) begin
      if (!cand_i[req_sel_q]) req_v_q <= 1'b0;
    end else if (pick_v) begin
      req_v_q   <= 1'b1;
      req_sel_q <= pick;
    end
  end

  assign req_o   = req_v_q;
  assign req_q_o = req_sel_q;
endmodule

// File: rtl/txq_sched.sv
module txq_sched
  import txq_sched_pkg::*;
#(
  parameter int NUM_Q  = 16,
  parameter int NUM_CH = 8,
  parameter int PTR_W  = 8,
  localparam int QW     = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
  localparam int IDX_W  = (QW > 2) ? QW : 2,
  localparam int ADDR_W = IDX_W + 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    reg_we_i,
  input  logic [ADDR_W-1:0]       reg_addr_i,
  input  logic [31:0]             reg_wdata_i,
  output logic [31:0]             reg_rdata_o,
  output logic [NUM_CH-1:0]       req_o,
  output logic [NUM_CH*QW-1:0]    req_q_o,
  output logic [NUM_CH*PTR_W-1:0] req_ptr_o,
  input  logic [NUM_CH-1:0]       gnt_i,
  output logic [NUM_Q-1:0]        irq_o
);
  logic [NUM_Q*PTR_W-1:0]   rd_flat;
  logic [NUM_Q-1:0]         elig, adv;
  logic [NUM_Q*ST_CH_W-1:0] qch;

  txq_regs #(.NUM_Q(NUM_Q), .NUM_CH(NUM_CH), .PTR_W(PTR_W), .IDX_W(IDX_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .adv_i   (adv),
    .rd_ptr_o(rd_flat),
    .elig_o  (elig),
    .qch_o   (qch),
    .irq_o   (irq_o)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [NUM_Q-1:0] cand;
    always_comb begin
      for (int q = 0; q < NUM_Q; q++)
        cand[q] = elig[q] && (qch[q*ST_CH_W +: ST_CH_W] == ST_CH_W'(c));
    end

    txq_arb #(.NUM_Q(NUM_Q), .QW(QW)) u_arb (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cand_i (cand),
      .gnt_i  (gnt_i[c]),
      .req_o  (req_o[c]),
      .req_q_o(req_q_o[c*QW +: QW])
    );

    assign req_ptr_o[c*PTR_W +: PTR_W] = rd_flat[req_q_o[c*QW +: QW]*PTR_W +: PTR_W];
  end

  // rings map to one channel each, so at most one channel advances a ring
  always_comb begin
    adv = '0;
    for (int c = 0; c < NUM_CH; c++)
      if (req_o[c] && gnt_i[c]) adv[req_q_o[c*QW +: QW]] = 1'b1;
  end
endmodule

// File: rtl/txq_sched_chk.sv
module txq_sched_chk #(
  parameter int NUM_Q  = 16,
  parameter int NUM_CH = 8,
  parameter int PTR_W  = 8,
  parameter int QW     = 4,
  parameter int IDX_W  = 4
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    reg_we_i,
  input logic [IDX_W+1:0]        reg_addr_i,
  input logic [31:0]             reg_wdata_i,
  input logic [NUM_CH-1:0]       req_o,
  input logic [NUM_CH*QW-1:0]    req_q_o,
  input logic [NUM_CH-1:0]       gnt_i,
  input logic [NUM_Q-1:0]        irq_o,
  input logic [NUM_Q*PTR_W-1:0]  rd_flat_i
);
  logic [NUM_Q-1:0] acc_q, sw_rd;
  logic unused_wdata;
  assign unused_wdata = ^reg_wdata_i[31:PTR_W];

  always_comb begin
    acc_q = '0;
    for (int c = 0; c < NUM_CH; c++)
      if (req_o[c] && gnt_i[c]) acc_q[req_q_o[c*QW +: QW]] = 1'b1;
  end

  for (genvar q = 0; q < NUM_Q; q++) begin : g_qa
    assign sw_rd[q] = reg_we_i && (reg_addr_i == {2'b10, IDX_W'(q)});

    assert_irq_after_grant_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[q] |-> $past(acc_q[q]));

    assert_rd_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (acc_q[q] && !sw_rd[q]) |=>
        rd_flat_i[q*PTR_W +: PTR_W] == PTR_W'($past(rd_flat_i[q*PTR_W +: PTR_W]) + 1'b1));

    assert_sw_rd_wins_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sw_rd[q] |=> rd_flat_i[q*PTR_W +: PTR_W] == $past(reg_wdata_i[PTR_W-1:0]));
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ca
    assert_req_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_o[c] && gnt_i[c]) |=> !req_o[c]);

    assert_req_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_o[c] && !gnt_i[c]) |=> (!req_o[c] || $stable(req_q_o[c*QW +: QW])));
  end
endmodule

bind txq_sched txq_sched_chk #(
  .NUM_Q(NUM_Q), .NUM_CH(NUM_CH), .PTR_W(PTR_W), .QW(QW), .IDX_W(IDX_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .req_o      (req_o),
  .req_q_o    (req_q_o),
  .gnt_i      (gnt_i),
  .irq_o      (irq_o),
  .rd_flat_i  (rd_flat)
);

// File: tb/txq_sched_tb_top.sv
module txq_sched_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NQ = 16;
  localparam int NC = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  req;
  logic [31:0] req_q;
  logic [63:0] req_ptr;
  logic [7:0]  gnt_auto = '0, gnt_force = '0, gnt;
  logic [15:0] irq;

  assign gnt = gnt_auto | gnt_force;

  txq_sched dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .req_o(req), .req_q_o(req_q),
    .req_ptr_o(req_ptr), .gnt_i(gnt), .irq_o(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit cmp_en = 0;
  int gnt_mode = 0;
  logic [31:0] lcg = 32'h1234_5678, lcg2 = 32'h0bad_cafe;
  int seq[$];

  // reference model state
  logic [7:0]  m_rd[NQ], m_wr[NQ];
  logic [9:0]  m_st[NQ];
  logic [7:0]  m_chen;
  logic [15:0] m_empty, m_chain, m_imask, m_irq;
  bit          m_rv[NC];
  int          m_rq[NC], m_last[NC];

  task automatic chk(string tag, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit m_elig(int q);
    int ch;
    ch = int'(m_st[q][4:1]);
    return m_st[q][0] && (m_rd[q] != m_wr[q]) && !m_empty[q] &&
           (!m_st[q][8] || m_st[q][5]) && ch < NC && m_chen[ch];
  endfunction

  function automatic logic [31:0] m_read(logic [5:0] a);
    int b, i;
    b = int'(a[5:4]);
    i = int'(a[3:0]);
    case (b)
      0: case (i)
           0: return {24'b0, m_chen};
           1: return {16'b0, m_empty};
           2: return {16'b0, m_chain};
           3: return {16'b0, m_imask};
           default: return 32'b0;
         endcase
      1: return {24'b0, m_wr[i]};
      2: return {24'b0, m_rd[i]};
      default: return {22'b0, m_st[i]};
    endcase
  endfunction

  function automatic string rd_tag(logic [5:0] a);
    case (a[5:4])
      2'd0: case (a[3:0])
              4'd0: return "R5";
              4'd1: return "R4";
              4'd2: return "R13";
              4'd3: return "R11";
              default: return "R2";
            endcase
      2'd1: return "R2";
      2'd2: return "R12";
      default: return "R3";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int q = 0; q < NQ; q++) begin m_rd[q] = 0; m_wr[q] = 0; m_st[q] = 0; end
      m_chen = 0; m_empty = 0; m_chain = 0; m_imask = 0; m_irq = 0;
      for (int c = 0; c < NC; c++) begin m_rv[c] = 0; m_rq[c] = 0; m_last[c] = NQ - 1; end
    end else begin
      bit el[NQ];
      bit ad[NQ];
      for (int q = 0; q < NQ; q++) begin el[q] = m_elig(q); ad[q] = 0; end
      for (int c = 0; c < NC; c++) begin
        if (m_rv[c] && gnt[c]) begin
          ad[m_rq[c]] = 1; m_last[c] = m_rq[c]; m_rv[c] = 0;
        end else if (m_rv[c]) begin
          if (!(el[m_rq[c]] && int'(m_st[m_rq[c]][4:1]) == c)) m_rv[c] = 0;
        end else begin
          for (int k = 1; k <= NQ; k++) begin
            int n;
            n = (m_last[c] + k) % NQ;
            if (!m_rv[c] && el[n] && int'(m_st[n][4:1]) == c) begin
              m_rv[c] = 1; m_rq[c] = n;
            end
          end
        end
      end
      for (int q = 0; q < NQ; q++) begin
        m_irq[q] = ad[q] && m_imask[q];
        if (ad[q]) m_rd[q] = m_rd[q] + 8'd1;
      end
      if (we) begin
        int i;
        i = int'(addr[3:0]);
        case (addr[5:4])
          2'd0: case (i)
                  0: m_chen = wdata[7:0];
                  1: m_empty = (m_empty & ~wdata[31:16]) | (wdata[15:0] & wdata[31:16]);
                  2: m_chain = wdata[15:0];
                  3: m_imask = wdata[15:0];
                  default: ;
                endcase
          2'd1: m_wr[i] = wdata[7:0];
          2'd2: m_rd[i] = wdata[7:0];
          default: m_st[i] = (m_st[i] & ~wdata[19:10]) | (wdata[9:0] & wdata[19:10]);
        endcase
      end
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    #1;
    if (cmp_en) begin
      for (int c = 0; c < NC; c++) begin
        chk("R7 req", req[c], m_rv[c]);
        if (m_rv[c]) begin
          chk("R9 req_q", req_q[c*4 +: 4], m_rq[c]);
          chk("R8 req_ptr", req_ptr[c*8 +: 8], m_rd[m_rq[c]]);
        end
      end
      chk("R11 irq", irq, m_irq);
      chk(rd_tag(addr), rdata, m_read(addr));
    end
  end

  // grant driver
  always @(negedge clk) begin
    lcg2 = lcg2 * 32'd1664525 + 32'd1013904223;
    case (gnt_mode)
      1: gnt_auto = req;
      2: gnt_auto = req & lcg2[15:8];
      default: gnt_auto = '0;
    endcase
    if (gnt_auto[0] && req[0]) seq.push_back(int'(req_q[3:0]));
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected below 100000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic wr_reg(logic [5:0] a, logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd_reg(logic [5:0] a, output logic [31:0] d);
    @(negedge clk); addr = a;
    #2 d = rdata;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    cmp_en = 1;
    @(negedge clk);
    #2;
    chk("R1 req", req, 0);
    chk("R1 irq", irq, 0);
    rd_reg(6'h33, v); chk("R1 status", v, 0);
    rd_reg(6'h00, v); chk("R1 chan_en", v, 0);

    // R5: channel disabled blocks, enabled releases
    wr_reg(6'h30, 32'h0000_7C05);
    wr_reg(6'h10, 32'd3);
    wait_cyc(3);
    chk("R5 disabled", req[2], 0);
    wr_reg(6'h00, 32'hFF);
    wait_cyc(2);
    chk("R7 raised", req[2], 1);
    chk("R7 ring", req_q[11:8], 0);
    chk("R7 ptr", req_ptr[23:16], 0);
    gnt_mode = 1;
    wait_cyc(10);
    rd_reg(6'h20, v); chk("R8 drained", v, 3);
    chk("R8 idle", req[2], 0);
    gnt_mode = 0;

    // R9: round robin on channel 0
    seq.delete();
    wr_reg(6'h31, 32'h0000_7C01); wr_reg(6'h11, 32'd2);
    wr_reg(6'h35, 32'h0000_7C01); wr_reg(6'h15, 32'd2);
    wr_reg(6'h39, 32'h0000_7C01); wr_reg(6'h19, 32'd2);
    gnt_mode = 1;
    wait_cyc(20);
    gnt_mode = 0;
    chk("R9 count", seq.size(), 6);
    if (seq.size() == 6) begin
      int exp_o[6] = '{1, 5, 9, 1, 5, 9};
      for (int i = 0; i < 6; i++) chk("R9 order", seq[i], exp_o[i]);
    end

    // R6: scheduler-ack mode needs window space
    wr_reg(6'h33, 32'h0007_FD03);
    wr_reg(6'h13, 32'd1);
    wait_cyc(3);
    chk("R6 no window", req[1], 0);
    wr_reg(6'h33, 32'h0000_8020);
    wait_cyc(2);
    chk("R6 window", req[1], 1);
    // R10 / R3: deactivate only
    wr_reg(6'h33, 32'h0000_0400);
    @(negedge clk);
    chk("R10 dropped", req[1], 0);
    rd_reg(6'h33, v); chk("R3 fields kept", v, 32'h122);

    // R4: empty flag holds a ring off
    wr_reg(6'h01, 32'h0010_0010);
    wr_reg(6'h03, 32'h0000_0010);
    wr_reg(6'h34, 32'h0000_7C07);
    wr_reg(6'h14, 32'd5);
    wait_cyc(3);
    chk("R4 held off", req[3], 0);
    rd_reg(6'h01, v); chk("R4 flag", v, 32'h10);
    wr_reg(6'h01, 32'h0010_0000);
    wait_cyc(3);
    chk("R4 released", req[3], 1);
    chk("R4 ring", req_q[15:12], 4);

    // R12: software write of consumer index collides with grant
    @(negedge clk); we = 1; addr = 6'h24; wdata = 32'h40; gnt_force = 8'h08;
    @(negedge clk); we = 0; gnt_force = 8'h00;
    #2;
    chk("R11 pulse", irq[4], 1);
    rd_reg(6'h24, v); chk("R12 sw wins", v, 32'h40);
    chk("R11 one cycle", irq[4], 0);

    // R8: index wraps modulo 256
    wr_reg(6'h26, 32'hFE);
    wr_reg(6'h16, 32'h01);
    wr_reg(6'h36, 32'h0000_7C09);
    gnt_mode = 1;
    wait_cyc(12);
    rd_reg(6'h26, v); chk("R8 wrap", v, 1);

    // R13: chain select storage
    wr_reg(6'h02, 32'h0000_A5A5);
    rd_reg(6'h02, v); chk("R13 readback", v, 32'hA5A5);

    // mixed random traffic, compared every clock
    gnt_mode = 2;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      lcg = lcg * 32'd1103515245 + 32'd12345;
      we = lcg[31] & lcg[29];
      addr = lcg[21:16];
      wdata = {lcg[15:0], lcg[30:15]};
      if (addr[5:4] == 2'b11) wdata[19:10] = lcg[9:0] | 10'h001;
    end
    @(negedge clk); we = 0;
    gnt_mode = 0;
    wait_cyc(4);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule